// File: doc/BRIEF.md
# Dual-Load-Register Interval Counter

This block times the spacing of output update pulses. It is a 24-bit down-counter that reloads from one of two 24-bit load registers, A or B. A 3-bit reload policy decides when the choice between A and B changes on its own. The policy can do one of three things: nothing, give the first interval after a re-arm event its own length, or swap the two registers at every stage boundary. The stage boundary is either a STOP or a terminal-count strobe from an external buffer counter.

Software programs the registers through a small write port and primes the counter with a load strobe. START lets it run, and it counts one step per enable tick. Each expiry produces a terminal-count strobe, reloads the counter in the same cycle and gives a one-cycle UPDATE pulse on the next cycle. The run state and the register that the next reload will use are both visible on output pins.

Top module: `ivl_update_timer`

## Requirements
- R1: After reset, cnt_state, next_src, update and tc are all 0. The counter and both load registers hold 0, and the policy is 0.
- R2: Register A is written at address 0 (data bits 7:0 become value bits 23:16) and at address 1 (data bits 15:0 become value bits 15:0). Register B uses addresses 2 and 3 in the same way. Writing a load register never changes the count.
- R3: START moves the control from WAIT (cnt_state 0) to CNT (cnt_state 1) on the next cycle. STOP moves it to WAIT. When both arrive in the same cycle, STOP wins.
- R4: In CNT, each tick decrements the count. A tick that finds the count at 1 or 0 raises tc in that same cycle and reloads the counter, so a load value N of 1 or more gives N ticks per interval. update is high for exactly the one cycle after each tc.
- R5: sw_load, STOP and tc each reload the counter from the register selected after any automatic change made in that cycle (next_src 0 = A, 1 = B).
- R6: A write to address 4 sets the policy from data bits 2:0 and sets next_src from data bit 3.
- R7: Policy 0 and the reserved values 1 to 3 never change next_src on their own.
- R8: Policy 4: STOP selects A. A tc that finds A selected switches to B, and the reload in that cycle uses B.
- R9: Policy 5: every STOP inverts next_src.
- R10: Policy 6: bc_tc selects A and reloads the counter from A. A tc that finds A selected switches to B, and that reload uses B.
- R11: Policy 7: every bc_tc inverts next_src. If bc_tc and tc fall in the same cycle, the reload uses the newly selected register.
- R12: In WAIT, ticks neither decrement the count nor raise tc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| sw_load | input | 1 | Software reload strobe |
| start | input | 1 | Start trigger |
| stop | input | 1 | Stop trigger |
| bc_tc | input | 1 | Terminal-count strobe from the buffer counter |
| tick | input | 1 | Count-enable tick |
| update | output | 1 | One-cycle update pulse |
| tc | output | 1 | Terminal-count strobe (combinational) |
| cnt_state | output | 1 | 0 = WAIT, 1 = CNT |
| next_src | output | 1 | Register used by the next reload: 0 = A, 1 = B |

## Verification
Two functions can land in the same cycle: a selection change (from STOP or bc_tc) and a reload (from expiry). The bench forces this under policy 7 by driving bc_tc together with the tick that ends an interval. The next interval must then run at B's length, not A's. A behavioural model is compared with the outputs on every clock, and the interval lengths measured in ticks are checked against values worked out from the requirements.

// File: rtl/ivut_pkg.sv
package ivut_pkg;

  localparam logic [2:0] POL_FIRST_STOP = 3'd4;
  localparam logic [2:0] POL_SWAP_STOP  = 3'd5;
  localparam logic [2:0] POL_FIRST_BC   = 3'd6;
  localparam logic [2:0] POL_SWAP_BC    = 3'd7;

  // Automatic selection update; 0 = register A, 1 = register B.
  function automatic logic f_next_sel(input logic [2:0] pol, input logic sel,
                                      input logic stop, input logic bc_tc,
                                      input logic tc);
    logic nx;
    nx = sel;
    case (pol)
      POL_FIRST_STOP: begin
        if (stop)           nx = 1'b0;
        else if (tc && !sel) nx = 1'b1;
      end
      POL_SWAP_STOP: if (stop) nx = ~sel;
      POL_FIRST_BC: begin
        if (bc_tc)          nx = 1'b0;
        else if (tc && !sel) nx = 1'b1;
      end
      POL_SWAP_BC:   if (bc_tc) nx = ~sel;
      default:       nx = sel;
    endcase
    return nx;
  endfunction

  // Policy 6 re-arm also reloads the counter.
  function automatic logic f_rearm(input logic [2:0] pol, input logic bc_tc);
    return (pol == POL_FIRST_BC) && bc_tc;
  endfunction

endpackage

// File: rtl/ivut_loadregs.sv
module ivut_loadregs #(
  parameter int CNT_W  = 24,
  parameter int HI_W   = 8,
  parameter int LO_W   = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LO_W-1:0]   wr_data,
  output logic [CNT_W-1:0]  load_a,
  output logic [CNT_W-1:0]  load_b,
  output logic [2:0]        pol_q,
  output logic              pol_wr,
  output logic              pol_sel
);
  localparam int NREG = 2;
  localparam logic [ADDR_W-1:0] POL_ADDR = ADDR_W'(2 * NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_ld
    logic [CNT_W-1:0] val_q;
    logic hi_hit, lo_hit;
    assign hi_hit = wr_en && (wr_addr == ADDR_W'(2 * i));
    assign lo_hit = wr_en && (wr_addr == ADDR_W'(2 * i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else begin
        if (hi_hit) val_q[CNT_W-1:LO_W] <= wr_data[HI_W-1:0];
        if (lo_hit) val_q[LO_W-1:0]     <= wr_data;
      end
    end
  end

  assign load_a  = g_ld[0].val_q;
  assign load_b  = g_ld[1].val_q;
  assign pol_wr  = wr_en && (wr_addr == POL_ADDR);
  assign pol_sel = wr_data[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= 3'd0;
    else if (pol_wr) pol_q <= wr_data[2:0];
  end
endmodule

// File: rtl/ivut_srcsel.sv
module ivut_srcsel
  import ivut_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pol_q,
  input  logic       pol_wr,
  input  logic       pol_sel,
  input  logic       stop,
  input  logic       bc_tc,
  input  logic       tc,
  output logic       sel_q,
  output logic       sel_nx,
  output logic       rearm
);
  assign sel_nx = f_next_sel(pol_q, sel_q, stop, bc_tc, tc);
  assign rearm  = f_rearm(pol_q, bc_tc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (pol_wr) sel_q <= pol_sel;
    else             sel_q <= sel_nx;
  end
endmodule

// File: rtl/ivut_downcnt.sv
module ivut_downcnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic             run_q,
  output logic             tc,
  output logic             upd_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q[CNT_W-1:1] == '0);
  assign tc     = run_q && tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (reload)             cnt_q <= load_val;
      else if (run_q && tick) cnt_q <= cnt_q - 1'b1;
      if (stop)               run_q <= 1'b0;
      else if (start)         run_q <= 1'b1;
      upd_q <= tc;
    end
  end
endmodule

// File: rtl/ivl_update_timer.sv
module ivl_update_timer #(
  parameter int CNT_W  = 24,
  parameter int HI_W   = 8,
  parameter int LO_W   = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LO_W-1:0]   wr_data,
  input  logic              sw_load,
  input  logic              start,
  input  logic              stop,
  input  logic              bc_tc,
  input  logic              tick,
  output logic              update,
  output logic              tc,
  output logic              cnt_state,
  output logic              next_src
);
  logic [CNT_W-1:0] load_a, load_b, load_val;
  logic [2:0]       mode_q;
  logic             mode_wr, mode_sel;
  logic             sel_q, sel_nx, rearm, reload;

  ivut_loadregs #(.CNT_W(CNT_W), .HI_W(HI_W), .LO_W(LO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_a(load_a), .load_b(load_b), .pol_q(mode_q), .pol_wr(mode_wr), .pol_sel(mode_sel)
  );

  ivut_srcsel u_sel (
    .clk(clk), .rst_n(rst_n), .pol_q(mode_q), .pol_wr(mode_wr), .pol_sel(mode_sel),
    .stop(stop), .bc_tc(bc_tc), .tc(tc), .sel_q(sel_q), .sel_nx(sel_nx), .rearm(rearm)
  );

  assign reload   = sw_load || tc || stop || rearm;
  assign load_val = sel_nx ? load_b : load_a;

  ivut_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick),
    .reload(reload), .load_val(load_val), .run_q(cnt_state), .tc(tc), .upd_q(update)
  );

  assign next_src = sel_q;
endmodule

// File: rtl/ivut_checker.sv
module ivut_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       stop,
  input logic       tick,
  input logic       bc_tc,
  input logic       mode_wr,
  input logic [2:0] mode_q,
  input logic       tc,
  input logic       update,
  input logic       cnt_state,
  input logic       next_src
);
  AST_TC_THEN_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) tc |=> update); // R4
  AST_UPDATE_HAS_TC: assert property (@(posedge clk) disable iff (!rst_n) update |-> $past(tc)); // R4
  AST_TC_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n) tc |-> (cnt_state && tick)); // R12
  AST_STOP_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n) stop |=> !cnt_state); // R3
  AST_START_TO_CNT: assert property (@(posedge clk) disable iff (!rst_n) (start && !stop) |=> cnt_state); // R3
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode_q < 3'd4 && !mode_wr) |=> $stable(next_src)); // R7
  AST_FIRST_STOP_A: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 3'd4 && stop && !mode_wr) |=> !next_src); // R8
  AST_SWAP_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 3'd5 && stop && !mode_wr) |=> (next_src != $past(next_src))); // R9
  AST_FIRST_BC_A: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 3'd6 && bc_tc && !mode_wr) |=> !next_src); // R10
  AST_SWAP_ON_BC: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 3'd7 && bc_tc && !mode_wr) |=> (next_src != $past(next_src))); // R11
endmodule

bind ivl_update_timer ivut_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick), .bc_tc(bc_tc),
  .mode_wr(mode_wr), .mode_q(mode_q), .tc(tc), .update(update),
  .cnt_state(cnt_state), .next_src(next_src)
);

// File: tb/tb_ivl_update_timer.sv
`timescale 1ns/1ps
module tb_ivl_update_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, sw_load = 1'b0, start = 1'b0, stop = 1'b0, bc_tc = 1'b0, tick = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic update, tc, cnt_state, next_src;

  int checks = 0, errors = 0;
  bit done = 0;
  // reference model state
  int ra = 0, rb = 0, pol = 0, rsel = 0, rcnt = 0, rrun = 0, rupd = 0, rtc = 0;
  bit seen_tc;

  always #5 clk = ~clk;

  ivl_update_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_load(sw_load), .start(start), .stop(stop), .bc_tc(bc_tc), .tick(tick),
    .update(update), .tc(tc), .cnt_state(cnt_state), .next_src(next_src)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int nsel;
    bit rl;
    nsel = rsel;
    if (pol == 4) begin
      if (stop) nsel = 0; else if (rtc && rsel == 0) nsel = 1;
    end else if (pol == 5) begin
      if (stop) nsel = 1 - rsel;
    end else if (pol == 6) begin
      if (bc_tc) nsel = 0; else if (rtc && rsel == 0) nsel = 1;
    end else if (pol == 7) begin
      if (bc_tc) nsel = 1 - rsel;
    end
    rl = sw_load || rtc || stop || (pol == 6 && bc_tc);
    if (rl) rcnt = (nsel == 1) ? rb : ra;
    else if (rrun && tick) rcnt = rcnt - 1;
    if (stop) rrun = 0; else if (start) rrun = 1;
    rupd = rtc;
    rsel = nsel;
    if (wr_en) begin
      case (wr_addr)
        3'd0: ra = (ra % 65536) + (wr_data % 256) * 65536;
        3'd1: ra = (ra / 65536) * 65536 + wr_data;
        3'd2: rb = (rb % 65536) + (wr_data % 256) * 65536;
        3'd3: rb = (rb / 65536) * 65536 + wr_data;
        3'd4: begin pol = wr_data % 8; rsel = (wr_data / 8) % 2; end
        default: ;
      endcase
    end
  endtask

  // One clock: compare before the edge, advance the model after it, clear pulses.
  task automatic cyc();
    @(negedge clk);
    #1;
    rtc = (rrun == 1 && tick && rcnt <= 1) ? 1 : 0;
    seen_tc = tc;
    chk("R4 tc", int'(tc), rtc);
    chk("R4 update", int'(update), rupd);
    chk("R3 cnt_state", int'(cnt_state), rrun);
    chk("R5 next_src", int'(next_src), rsel);
    @(posedge clk);
    #1;
    model_step();
    wr_en = 0; sw_load = 0; start = 0; stop = 0; bc_tc = 0; tick = 0;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
    cyc();
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int k = 0; k < 70000; k++) begin
      tick = 1;
      cyc();
      n++;
      if (seen_tc) break;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    #2;
    chk("R1 cnt_state", int'(cnt_state), 0);
    chk("R1 next_src", int'(next_src), 0);
    chk("R1 update", int'(update), 0);
    chk("R1 tc", int'(tc), 0);
    cyc();

    // R2 load registers A=5, B=3
    wr(0, 0); wr(1, 5); wr(2, 0); wr(3, 3);
    // R12 ticks in WAIT with zero count
    for (int k = 0; k < 4; k++) begin tick = 1; cyc(); chk("R12 no tc in WAIT", int'(seen_tc), 0); end
    sw_load = 1; cyc();
    for (int k = 0; k < 10; k++) begin tick = 1; cyc(); end
    start = 1; cyc();
    chk("R3 start enters CNT", int'(cnt_state), 1);
    measure(n); chk("R12 R4 R5 first period after idle ticks", n, 5);
    measure(n); chk("R7 mode0 period", n, 5);

    // R3 start and stop together
    stop = 1; cyc();
    start = 1; stop = 1; cyc();
    chk("R3 stop wins", int'(cnt_state), 0);

    // R6 reserved policy 1 with select B
    wr(4, 1 + 8);
    chk("R6 select bit", int'(next_src), 1);
    stop = 1; cyc();
    start = 1; cyc();
    measure(n); chk("R7 reserved period B", n, 3);
    measure(n); chk("R7 reserved keeps B", n, 3);
    chk("R7 next_src held", int'(next_src), 1);

    // R8 policy 4
    wr(4, 4 + 8);
    stop = 1; cyc();
    chk("R8 stop selects A", int'(next_src), 0);
    start = 1; cyc();
    measure(n); chk("R8 first period A", n, 5);
    chk("R8 switched to B", int'(next_src), 1);
    measure(n); chk("R8 later period B", n, 3);
    measure(n); chk("R8 later period B again", n, 3);

    // R9 policy 5
    wr(4, 5);
    stop = 1; cyc();
    chk("R9 toggled to B", int'(next_src), 1);
    start = 1; cyc();
    measure(n); chk("R9 stage at B", n, 3);
    stop = 1; cyc();
    chk("R9 toggled to A", int'(next_src), 0);
    start = 1; cyc();
    measure(n); chk("R9 stage at A", n, 5);

    // R10 policy 6
    wr(4, 6 + 8);
    stop = 1; cyc();
    start = 1; cyc();
    measure(n); chk("R10 running at B", n, 3);
    tick = 1; cyc();
    bc_tc = 1; cyc();
    chk("R10 bc_tc selects A", int'(next_src), 0);
    measure(n); chk("R10 rearmed period A", n, 5);
    measure(n); chk("R10 then B", n, 3);

    // R11 policy 7, bc_tc coinciding with expiry
    wr(4, 7);
    stop = 1; cyc();
    start = 1; cyc();
    for (int k = 0; k < 4; k++) begin tick = 1; cyc(); end
    tick = 1; bc_tc = 1; cyc();
    chk("R11 tc with bc_tc", int'(seen_tc), 1);
    chk("R11 toggled to B", int'(next_src), 1);
    measure(n); chk("R11 reload used new register", n, 3);

    // R2 wide value through both pieces: A = 0x010002
    wr(4, 0);
    stop = 1; cyc();
    wr(0, 16'hFF01); wr(1, 2);
    sw_load = 1; cyc();
    start = 1; cyc();
    measure(n); chk("R2 split load value", n, 65538);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule